// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a segment value and a 16-bit offset into a 20-bit physical memory address, in the way a real-mode 16-bit processor does. The segment value is shifted left by four bits and the offset is added to it. The caller supplies several inputs: the four segment registers, the four registers that can serve as a pointer (BX, BP, SI, DI), the displacement taken from the instruction, and a mode code. The block then picks the offset and the segment by itself. The segment is implied by the register that the mode names, so no separate segment select input exists.

The block produces two addresses. The first is the address of the low byte of an access. The second is the address of the following byte, which a word access uses for its high byte. If the mode code is one of the reserved values, the block raises an error flag and drives both addresses to zero. With the default parameters, all results pass through one output register stage, so they appear one clock after the inputs.

Top module: `seg_ea_gen`

## Requirements
- R1: With `mode` = 2'b00 (direct), the offset is `disp` and the data segment is used: `addr_lo` = (`seg_data`·16 + `disp`) mod 2^20. For example, segment 1000h with offset 7000h gives 17000h.
- R2: With `mode` = 2'b01 (register indirect) and `base_sel` equal to 2'b00 (BX), 2'b10 (SI) or 2'b11 (DI), the offset is the named register and the data segment is used. For example, data segment 0800h with SI = 2000h gives 0A000h.
- R3: With `mode` = 2'b01 and `base_sel` = 2'b01 (BP), the offset is `reg_bp` and the stack segment is used. For example, stack segment 0800h with BP = 2000h gives 0A000h.
- R4: The sum wraps modulo 2^20, and any carry out of bit 19 is dropped. For example, FFFFh:FFFFh gives 0FFEFh.
- R5: For a valid mode, `addr_hi` = (`addr_lo` + 1) mod 2^20. For example, an address of FFFFFh gives 00000h.
- R6: With `mode` = 2'b10 or 2'b11, `mode_err` is 1 and both `addr_lo` and `addr_hi` are 0. For valid modes, `mode_err` is 0.
- R7: Outputs are registered. They change only on a rising clock edge and show the inputs sampled at that edge. While `rst_n` is low, all outputs are 0.
- R8: `seg_code` and `seg_extra` never affect the result. In direct mode, `base_sel` and the four pointer registers have no effect either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous reset, active low |
| seg_code | input | 16 | Code segment register |
| seg_data | input | 16 | Data segment register |
| seg_stack | input | 16 | Stack segment register |
| seg_extra | input | 16 | Extra segment register |
| reg_bx | input | 16 | BX pointer register |
| reg_bp | input | 16 | BP pointer register |
| reg_si | input | 16 | SI pointer register |
| reg_di | input | 16 | DI pointer register |
| disp | input | 16 | Displacement from the instruction |
| mode | input | 2 | 00 direct, 01 register indirect, 10/11 reserved |
| base_sel | input | 2 | Pointer register for indirect mode: 00 BX, 01 BP, 10 SI, 11 DI |
| addr_lo | output | 20 | Physical address of the low byte |
| addr_hi | output | 20 | Physical address of the following byte |
| mode_err | output | 1 | Reserved mode code seen |

## Verification
The assertions assume that the inputs are stable around each rising edge, so that the values captured there are the ones that `$past` reports one cycle later. They also ignore the first edge after reset, when the output register still holds its reset value. The bench changes every input only on the falling edge and never leaves an input undriven. This keeps the design within those assumptions. Within them, the random stimulus covers every mode code, including the reserved ones, every `base_sel` value and the full 16-bit range of each register.

// File: rtl/seg_ea_pkg.sv
package seg_ea_pkg;

  typedef enum logic [1:0] {
    MODE_DIRECT   = 2'b00,
    MODE_INDIRECT = 2'b01,
    MODE_RSVD_A   = 2'b10,
    MODE_RSVD_B   = 2'b11
  } ea_mode_e;

  typedef enum logic [1:0] {
    PTR_BX = 2'b00,
    PTR_BP = 2'b01,
    PTR_SI = 2'b10,
    PTR_DI = 2'b11
  } ea_ptr_e;

  typedef enum logic [1:0] {
    SEGSEL_CODE  = 2'b00,
    SEGSEL_DATA  = 2'b01,
    SEGSEL_STACK = 2'b10,
    SEGSEL_EXTRA = 2'b11
  } ea_seg_e;

endpackage

// File: rtl/seg_ea_route.sv
module seg_ea_route
  import seg_ea_pkg::*;
#(
  parameter int OFF_W = 16
) (
  input  logic [1:0]       mode,
  input  logic [1:0]       base_sel,
  input  logic [OFF_W-1:0] reg_bx,
  input  logic [OFF_W-1:0] reg_bp,
  input  logic [OFF_W-1:0] reg_si,
  input  logic [OFF_W-1:0] reg_di,
  input  logic [OFF_W-1:0] disp,
  output logic [OFF_W-1:0] offset,
  output ea_seg_e          seg_pick,
  output logic             bad_mode
);

  ea_mode_e mode_q;
  ea_ptr_e  ptr_q;

  assign mode_q = ea_mode_e'(mode);
  assign ptr_q  = ea_ptr_e'(base_sel);

  always_comb begin
    offset   = '0;
    seg_pick = SEGSEL_DATA;
    bad_mode = 1'b0;
    unique case (mode_q)
      MODE_DIRECT: begin
        offset = disp;
      end
      MODE_INDIRECT: begin
        unique case (ptr_q)
          PTR_BX: offset = reg_bx;
          PTR_BP: begin
            offset   = reg_bp;
            seg_pick = SEGSEL_STACK;
          end
          PTR_SI: offset = reg_si;
          PTR_DI: offset = reg_di;
        endcase
      end
      MODE_RSVD_A, MODE_RSVD_B: begin
        bad_mode = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/seg_ea_segmux.sv
module seg_ea_segmux
  import seg_ea_pkg::*;
#(
  parameter int SEG_W   = 16,
  parameter int N_SEG   = 4
) (
  input  logic [N_SEG-1:0][SEG_W-1:0] seg_bank,
  input  ea_seg_e                     seg_pick,
  output logic [SEG_W-1:0]            seg_val
);

  localparam int SEL_W = $clog2(N_SEG);

  logic [N_SEG-1:0]            hit;
  logic [N_SEG-1:0][SEG_W-1:0] masked;

  for (genvar g = 0; g < N_SEG; g++) begin : g_lane
    assign hit[g]    = (SEL_W'(seg_pick) == SEL_W'(g));
    assign masked[g] = hit[g] ? seg_bank[g] : '0;
  end

  always_comb begin
    seg_val = '0;
    for (int k = 0; k < N_SEG; k++) seg_val = seg_val | masked[k];
  end

endmodule

// File: rtl/seg_ea_sum.sv
module seg_ea_sum #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4
) (
  input  logic [SEG_W-1:0]       seg_val,
  input  logic [OFF_W-1:0]       offset,
  input  logic                   bad_mode,
  output logic [SEG_W+SHIFT-1:0] lo_addr,
  output logic [SEG_W+SHIFT-1:0] hi_addr
);

  localparam int ADDR_W = SEG_W + SHIFT;

  function automatic logic [ADDR_W-1:0] seg_base(input logic [SEG_W-1:0] s);
    return {s, {SHIFT{1'b0}}};
  endfunction

  function automatic logic [ADDR_W-1:0] phys(input logic [SEG_W-1:0] s,
                                             input logic [OFF_W-1:0] o);
    return seg_base(s) + ADDR_W'(o);
  endfunction

  function automatic logic [ADDR_W-1:0] next_byte(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  logic [ADDR_W-1:0] raw_lo;

  assign raw_lo  = phys(seg_val, offset);
  assign lo_addr = bad_mode ? '0 : raw_lo;
  assign hi_addr = bad_mode ? '0 : next_byte(raw_lo);

endmodule

// File: rtl/seg_ea_stage.sv
module seg_ea_stage #(
  parameter int W       = 41,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  if (REG_OUT) begin : g_flop
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end
  end else begin : g_wire
    logic unused_clk;
    assign unused_clk = clk ^ rst_n;
    assign q = d;
  end

endmodule

// File: rtl/seg_ea_gen.sv
module seg_ea_gen
  import seg_ea_pkg::*;
#(
  parameter int SEG_W   = 16,
  parameter int OFF_W   = 16,
  parameter int SHIFT   = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [SEG_W-1:0]       seg_code,
  input  logic [SEG_W-1:0]       seg_data,
  input  logic [SEG_W-1:0]       seg_stack,
  input  logic [SEG_W-1:0]       seg_extra,
  input  logic [OFF_W-1:0]       reg_bx,
  input  logic [OFF_W-1:0]       reg_bp,
  input  logic [OFF_W-1:0]       reg_si,
  input  logic [OFF_W-1:0]       reg_di,
  input  logic [OFF_W-1:0]       disp,
  input  logic [1:0]             mode,
  input  logic [1:0]             base_sel,
  output logic [SEG_W+SHIFT-1:0] addr_lo,
  output logic [SEG_W+SHIFT-1:0] addr_hi,
  output logic                   mode_err
);

  localparam int ADDR_W  = SEG_W + SHIFT;
  localparam int STAGE_W = 2 * ADDR_W + 1;

  // internal events, named for the checker
  logic [OFF_W-1:0]          ev_offset;
  ea_seg_e                   ev_seg_pick;
  logic                      ev_bad_mode;
  logic [SEG_W-1:0]          ev_seg_val;
  logic [ADDR_W-1:0]         ev_lo;
  logic [ADDR_W-1:0]         ev_hi;
  logic [3:0][SEG_W-1:0]     seg_bank;
  logic [STAGE_W-1:0]        stage_q;

  assign seg_bank[SEGSEL_CODE]  = seg_code;
  assign seg_bank[SEGSEL_DATA]  = seg_data;
  assign seg_bank[SEGSEL_STACK] = seg_stack;
  assign seg_bank[SEGSEL_EXTRA] = seg_extra;

  seg_ea_route #(.OFF_W(OFF_W)) u_route (
    .mode     (mode),
    .base_sel (base_sel),
    .reg_bx   (reg_bx),
    .reg_bp   (reg_bp),
    .reg_si   (reg_si),
    .reg_di   (reg_di),
    .disp     (disp),
    .offset   (ev_offset),
    .seg_pick (ev_seg_pick),
    .bad_mode (ev_bad_mode)
  );

  seg_ea_segmux #(.SEG_W(SEG_W), .N_SEG(4)) u_segmux (
    .seg_bank (seg_bank),
    .seg_pick (ev_seg_pick),
    .seg_val  (ev_seg_val)
  );

  seg_ea_sum #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_sum (
    .seg_val  (ev_seg_val),
    .offset   (ev_offset),
    .bad_mode (ev_bad_mode),
    .lo_addr  (ev_lo),
    .hi_addr  (ev_hi)
  );

  seg_ea_stage #(.W(STAGE_W), .REG_OUT(REG_OUT)) u_stage (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({ev_bad_mode, ev_hi, ev_lo}),
    .q     (stage_q)
  );

  assign addr_lo  = stage_q[ADDR_W-1:0];
  assign addr_hi  = stage_q[2*ADDR_W-1:ADDR_W];
  assign mode_err = stage_q[STAGE_W-1];

endmodule

// File: rtl/seg_ea_gen_chk.sv
module seg_ea_gen_chk #(
  parameter int SEG_W   = 16,
  parameter int OFF_W   = 16,
  parameter int SHIFT   = 4,
  parameter bit REG_OUT = 1'b1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [SEG_W-1:0]       seg_data,
  input logic [SEG_W-1:0]       seg_stack,
  input logic [OFF_W-1:0]       reg_bp,
  input logic [OFF_W-1:0]       disp,
  input logic [1:0]             mode,
  input logic [1:0]             base_sel,
  input logic [SEG_W+SHIFT-1:0] addr_lo,
  input logic [SEG_W+SHIFT-1:0] addr_hi,
  input logic                   mode_err
);

  localparam int ADDR_W = SEG_W + SHIFT;

  logic primed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  p_hi_after_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !mode_err) |-> (addr_hi == addr_lo + ADDR_W'(1)));

  p_err_zeroes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && mode_err) |-> (addr_lo == '0 && addr_hi == '0));

  if (REG_OUT) begin : g_seq
    p_err_tracks_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
      primed |-> (mode_err == $past(mode[1])));

    p_direct_data_seg_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && $past(mode) == 2'b00) |->
        (addr_lo == ADDR_W'({$past(seg_data), {SHIFT{1'b0}}}) + ADDR_W'($past(disp))));

    p_bp_stack_seg_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && $past(mode) == 2'b01 && $past(base_sel) == 2'b01) |->
        (addr_lo == ADDR_W'({$past(seg_stack), {SHIFT{1'b0}}}) + ADDR_W'($past(reg_bp))));
  end

endmodule

bind seg_ea_gen seg_ea_gen_chk #(
  .SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .REG_OUT(REG_OUT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .seg_data  (seg_data),
  .seg_stack (seg_stack),
  .reg_bp    (reg_bp),
  .disp      (disp),
  .mode      (mode),
  .base_sel  (base_sel),
  .addr_lo   (addr_lo),
  .addr_hi   (addr_hi),
  .mode_err  (mode_err)
);

// File: tb/test_seg_ea_gen.sv
`timescale 1ns/1ps
module test_seg_ea_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] seg_code = '0, seg_data = '0, seg_stack = '0, seg_extra = '0;
  logic [15:0] reg_bx = '0, reg_bp = '0, reg_si = '0, reg_di = '0, disp = '0;
  logic [1:0]  mode = '0, base_sel = '0;
  logic [19:0] addr_lo, addr_hi;
  logic        mode_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  seg_ea_gen i_seg_ea_gen (
    .clk(clk), .rst_n(rst_n),
    .seg_code(seg_code), .seg_data(seg_data), .seg_stack(seg_stack), .seg_extra(seg_extra),
    .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
    .disp(disp), .mode(mode), .base_sel(base_sel),
    .addr_lo(addr_lo), .addr_hi(addr_hi), .mode_err(mode_err)
  );

  // reference: integer arithmetic, reduced with modulo
  function automatic void model(output logic [19:0] lo, output logic [19:0] hi,
                                output logic err);
    int unsigned s, o;
    err = 1'b0;
    s = seg_data;
    o = disp;
    if (mode >= 2) begin
      err = 1'b1;
      lo = '0;
      hi = '0;
      return;
    end
    if (mode == 1) begin
      case (base_sel)
        2'd0: o = reg_bx;
        2'd1: begin o = reg_bp; s = seg_stack; end
        2'd2: o = reg_si;
        default: o = reg_di;
      endcase
    end
    lo = 20'((s * 16 + o) % 32'h100000);
    hi = 20'((s * 16 + o + 1) % 32'h100000);
  endfunction

  task automatic check(input string tag, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%05h expected=%05h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // drive on negedge, let one posedge capture, sample at next negedge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    logic [19:0] elo, ehi;
    logic        eerr;
    model(elo, ehi, eerr);
    check({tag, " lo"}, addr_lo, elo);
    check({tag, " hi"}, addr_hi, ehi);
    check({tag, " err"}, {19'd0, mode_err}, {19'd0, eerr});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [19:0] keep_lo;
    void'($urandom(32'h5EA1_2024));
    @(negedge clk);
    seg_data = 16'h1234; disp = 16'h5678;
    @(negedge clk);
    // R7: reset holds outputs at zero
    check("R7 reset lo", addr_lo, 20'h0);
    check("R7 reset hi", addr_hi, 20'h0);
    check("R7 reset err", {19'd0, mode_err}, 20'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 and R5: direct, 1000h:7000h
    seg_data = 16'h1000; disp = 16'h7000; mode = 2'b00; base_sel = 2'b01;
    step();
    check("R1 direct", addr_lo, 20'h17000);
    check("R5 second byte", addr_hi, 20'h17001);

    // R2: SI with data segment
    seg_data = 16'h0800; seg_stack = 16'h3333; reg_si = 16'h2000; mode = 2'b01; base_sel = 2'b10;
    step();
    check("R2 si", addr_lo, 20'h0A000);
    // R2: BX and DI
    reg_bx = 16'h0010; base_sel = 2'b00;
    step();
    check("R2 bx", addr_lo, 20'h08010);
    reg_di = 16'hFFFF; base_sel = 2'b11;
    step();
    check("R2 di", addr_lo, 20'h17FFF);

    // R3: BP with stack segment
    seg_stack = 16'h0800; seg_data = 16'h4444; reg_bp = 16'h2000; base_sel = 2'b01;
    step();
    check("R3 bp", addr_lo, 20'h0A000);

    // R4: carry out of bit 19 dropped
    seg_data = 16'hFFFF; disp = 16'hFFFF; mode = 2'b00;
    step();
    check("R4 wrap", addr_lo, 20'h0FFEF);
    check("R4 wrap hi", addr_hi, 20'h0FFF0);

    // R5: second byte wraps past FFFFFh
    seg_data = 16'hF000; disp = 16'hFFFF;
    step();
    check("R5 lo at top", addr_lo, 20'hFFFFF);
    check("R5 hi wraps", addr_hi, 20'h00000);

    // R6: reserved modes
    mode = 2'b10;
    step();
    check("R6 mode10 lo", addr_lo, 20'h0);
    check("R6 mode10 hi", addr_hi, 20'h0);
    check("R6 mode10 err", {19'd0, mode_err}, 20'h1);
    mode = 2'b11;
    step();
    check("R6 mode11 err", {19'd0, mode_err}, 20'h1);
    check("R6 mode11 lo", addr_lo, 20'h0);

    // R8: direct mode ignores pointers, base_sel, code and extra segments
    seg_data = 16'h2000; disp = 16'h0123; mode = 2'b00;
    step();
    keep_lo = addr_lo;
    check("R8 baseline", keep_lo, 20'h20123);
    for (int i = 0; i < 8; i++) begin
      seg_code = 16'($urandom); seg_extra = 16'($urandom);
      reg_bx = 16'($urandom); reg_bp = 16'($urandom);
      reg_si = 16'($urandom); reg_di = 16'($urandom);
      base_sel = 2'($urandom);
      step();
      check("R8 unaffected", addr_lo, keep_lo);
    end

    // R7: output holds between edges
    disp = 16'h0F00;
    #1;
    check("R7 held before edge", addr_lo, keep_lo);
    step();
    check("R7 updated after edge", addr_lo, 20'h20F00);

    // random mix over all modes and registers
    for (int i = 0; i < 400; i++) begin
      seg_code = 16'($urandom); seg_data = 16'($urandom);
      seg_stack = 16'($urandom); seg_extra = 16'($urandom);
      reg_bx = 16'($urandom); reg_bp = 16'($urandom);
      reg_si = 16'($urandom); reg_di = 16'($urandom);
      disp = 16'($urandom);
      mode = ($urandom_range(0, 7) == 0) ? 2'($urandom_range(2, 3)) : 2'($urandom_range(0, 1));
      base_sel = 2'($urandom);
      step();
      check_all("R1 R2 R3 R4 R5 R6 random");
    end

    // R7: reset mid-run clears outputs
    rst_n = 1'b0;
    #1;
    check("R7 async clear", addr_lo, 20'h0);
    check("R7 async clear err", {19'd0, mode_err}, 20'h0);
    @(negedge clk);
    finish_run();
  end

endmodule